// File: doc/BRIEF.md
# Programmable CRC-32 Register Engine

A register-mapped checksum engine for a simple 32-bit bus with byte enables. Software programs a 32-bit generator polynomial and a 32-bit seed, then writes a control word whose lowest bit loads the seed and polynomial into the running engine. Data is then streamed in by writing the data register. A write with all four byte enables set advances the checksum by a full 32-bit word. A write with exactly one byte enable set advances it by the single byte on that lane. Both kinds of write complete in one clock.

The input bits can be reordered before they are consumed: within each byte, within each 16-bit half, or across the whole word. The value read back from the data register can be bit-reversed. With these options, software can compute both MSB-first CRCs and reflected (LSB-first) CRCs.

Reading the data register returns the running checksum. Software can save that value, write it back as the seed later and issue a load, and the computation continues exactly where it stopped. Any final inversion is left to software.

Top module: `prog_crc_unit`

## Requirements
- R1: After synchronous reset the seed register reads 0xFFFFFFFF, the polynomial register reads 0x04C11DB7, the control register reads 0, and the data register reads 0xFFFFFFFF.
- R2: Register offsets are data 0x00, control 0x08, seed 0x10 and polynomial 0x14. A write to control with byte enable 0 set and bit 0 set copies the seed and polynomial registers into the engine. Control bit 0 always reads as 0.
- R3: A data write with byte enables 4'b1111 advances the checksum over 32 bits, MSB first: for each bit b, the feedback f = crc[31]^b and the new crc = (crc<<1) ^ (f ? poly : 0).
- R4: A data write with exactly one byte enable set advances the checksum over 8 bits taken from that lane, MSB first. A data write with any other byte-enable pattern leaves the checksum unchanged.
- R5: Control bits [6:5] choose the reordering of a word input: 00 none, 01 reverse the bits of each byte, 10 reverse the bits of each 16-bit half, 11 reverse all 32 bits.
- R6: For a single-byte input, any nonzero code in control bits [6:5] reverses the 8 bits of that byte, and code 00 leaves the byte as it is.
- R7: When control bit 7 is set, a read of the data register returns the checksum with all 32 bits reversed. Control reads back bits [7:5] as written.
- R8: A control write with bit 0 clear changes only the modes and leaves the checksum unchanged.
- R9: Writes to the seed or polynomial register do not alter the checksum. Later data keeps using the polynomial captured at the last load, until the next load.
- R10: Writing a value read from the data register (with bit 7 clear) back as the seed and then loading continues the computation exactly.
- R11: A read returns its data with a valid strobe exactly one cycle after the request. The strobe is low otherwise. The value read reflects every data write completed before the read, including one in the immediately preceding cycle.
- R12: A single control write that both loads and changes the input mode takes effect fully: the checksum equals the seed, and the next data write uses the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_be | input | 4 | Byte enables for a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | High for one cycle when bus_rdata holds read data |

## Verification
Only one bus access can happen per cycle. The two functions that can land in the same cycle are therefore the engine load and the input-mode change, both carried by one control write. The bench issues that combined write in the middle of a stream. It then checks that the data register equals the seed and that the next byte is taken with the new reordering. It also places a data read in the cycle right after a data write, to confirm that the read returns the freshly advanced value and not the old one. Randomly mixed load and mode writes, compared against the bench's bit-serial model, cover the other combinations.

// File: rtl/crc_unit_pkg.sv
package crc_unit_pkg;
  localparam int unsigned CRC_W  = 32;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = CRC_W / LANE_W;

  typedef enum logic [1:0] {
    REV_NONE = 2'b00,
    REV_BYTE = 2'b01,
    REV_HALF = 2'b10,
    REV_WORD = 2'b11
  } rev_mode_e;

  function automatic logic [CRC_W-1:0] flip_word(input logic [CRC_W-1:0] x);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = x[CRC_W-1-i];
    return r;
  endfunction

  function automatic logic [LANE_W-1:0] flip_lane(input logic [LANE_W-1:0] x);
    logic [LANE_W-1:0] r;
    for (int i = 0; i < LANE_W; i++) r[i] = x[LANE_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/crc_in_reorder.sv
module crc_in_reorder
  import crc_unit_pkg::*;
#(
  parameter int unsigned W    = CRC_W,
  parameter int unsigned LANE = LANE_W
) (
  input  rev_mode_e      mode,
  input  logic [W-1:0]   din,
  output logic [W-1:0]   dout
);
  localparam int unsigned NSIZES = 3;

  // one candidate per group size: LANE, 2*LANE, 4*LANE
  for (genvar s = 0; s < NSIZES; s++) begin : g_size
    localparam int unsigned G = LANE << s;
    logic [W-1:0] r;
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign r[i] = din[(i / G) * G + G - 1 - (i % G)];
    end
  end

  always_comb begin
    unique case (mode)
      REV_NONE: dout = din;
      REV_BYTE: dout = g_size[0].r;
      REV_HALF: dout = g_size[1].r;
      default:  dout = g_size[2].r;
    endcase
  end
endmodule

// File: rtl/crc_advance.sv
module crc_advance
  import crc_unit_pkg::*;
#(
  parameter int unsigned CW   = CRC_W,
  parameter int unsigned IN_W = CRC_W
) (
  input  logic [CW-1:0]   crc_in,
  input  logic [CW-1:0]   poly,
  input  logic [IN_W-1:0] din,
  output logic [CW-1:0]   crc_out
);
  logic [CW-1:0] c;
  logic          fb;

  // unrolled MSB-first shift/XOR over the whole input
  always_comb begin
    c  = crc_in;
    fb = 1'b0;
    for (int i = IN_W - 1; i >= 0; i--) begin
      fb = c[CW-1] ^ din[i];
      c  = {c[CW-2:0], 1'b0} ^ ({CW{fb}} & poly);
    end
    crc_out = c;
  end
endmodule

// File: rtl/crc_regfile.sv
module crc_regfile
  import crc_unit_pkg::*;
#(
  parameter int unsigned      ADDR_W   = 5,
  parameter logic [CRC_W-1:0] RST_SEED = 32'hFFFF_FFFF,
  parameter logic [CRC_W-1:0] RST_POLY = 32'h04C1_1DB7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  be,
  input  logic [CRC_W-1:0]  wdata,
  input  logic [CRC_W-1:0]  acc,
  output logic [CRC_W-1:0]  rdata,
  output logic              rvalid,
  output logic [CRC_W-1:0]  seed_q,
  output logic [CRC_W-1:0]  poly_q,
  output rev_mode_e         rev_in,
  output logic              rev_out,
  output logic              load_p,
  output logic              word_we,
  output logic              byte_we,
  output logic [LANE_W-1:0] byte_val
);
  localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] OFS_SEED = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] OFS_POLY = ADDR_W'('h14);

  logic wr, rd;
  logic hit_data, hit_ctrl, hit_seed, hit_poly;
  logic unused_wbits;

  assign wr       = sel & we;
  assign rd       = sel & ~we;
  assign hit_data = (addr == OFS_DATA);
  assign hit_ctrl = (addr == OFS_CTRL);
  assign hit_seed = (addr == OFS_SEED);
  assign hit_poly = (addr == OFS_POLY);
  assign unused_wbits = ^{wdata[CRC_W-1:LANE_W], wdata[4:1]};

  // seed and polynomial registers, written lane by lane
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        seed_q[l*LANE_W +: LANE_W] <= RST_SEED[l*LANE_W +: LANE_W];
        poly_q[l*LANE_W +: LANE_W] <= RST_POLY[l*LANE_W +: LANE_W];
      end else begin
        if (wr && hit_seed && be[l]) seed_q[l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
        if (wr && hit_poly && be[l]) poly_q[l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
      end
    end
  end

  // mode bits of the control register
  always_ff @(posedge clk) begin
    if (rst) begin
      rev_in  <= REV_NONE;
      rev_out <= 1'b0;
    end else if (wr && hit_ctrl && be[0]) begin
      rev_in  <= rev_mode_e'(wdata[6:5]);
      rev_out <= wdata[7];
    end
  end

  // strobes towards the engine
  assign load_p  = wr & hit_ctrl & be[0] & wdata[0];
  assign word_we = wr & hit_data & (be == {LANES{1'b1}});
  assign byte_we = wr & hit_data & $onehot(be);

  always_comb begin
    byte_val = '0;
    for (int l = 0; l < LANES; l++)
      if (be[l]) byte_val = byte_val | wdata[l*LANE_W +: LANE_W];
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) begin
        unique case (1'b1)
          hit_data: rdata <= rev_out ? flip_word(acc) : acc;
          hit_ctrl: rdata <= {{(CRC_W-8){1'b0}}, rev_out, rev_in, 5'b0};
          hit_seed: rdata <= seed_q;
          hit_poly: rdata <= poly_q;
          default:  rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/prog_crc_unit.sv
module prog_crc_unit
  import crc_unit_pkg::*;
#(
  parameter int unsigned      ADDR_W   = 5,
  parameter logic [CRC_W-1:0] RST_SEED = 32'hFFFF_FFFF,
  parameter logic [CRC_W-1:0] RST_POLY = 32'h04C1_1DB7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LANES-1:0]  bus_be,
  input  logic [CRC_W-1:0]  bus_wdata,
  output logic [CRC_W-1:0]  bus_rdata,
  output logic              bus_rvalid
);
  logic [CRC_W-1:0]  acc_q, act_poly_q;
  logic [CRC_W-1:0]  seed_val, poly_val;
  rev_mode_e         rev_in;
  logic              rev_out;
  logic              load_p, word_we, byte_we;
  logic [LANE_W-1:0] byte_val, byte_in;
  logic [CRC_W-1:0]  word_in, nxt_word, nxt_byte;

  crc_regfile #(
    .ADDR_W  (ADDR_W),
    .RST_SEED(RST_SEED),
    .RST_POLY(RST_POLY)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .sel     (bus_sel),
    .we      (bus_we),
    .addr    (bus_addr),
    .be      (bus_be),
    .wdata   (bus_wdata),
    .acc     (acc_q),
    .rdata   (bus_rdata),
    .rvalid  (bus_rvalid),
    .seed_q  (seed_val),
    .poly_q  (poly_val),
    .rev_in  (rev_in),
    .rev_out (rev_out),
    .load_p  (load_p),
    .word_we (word_we),
    .byte_we (byte_we),
    .byte_val(byte_val)
  );

  crc_in_reorder #(.W(CRC_W), .LANE(LANE_W)) u_reorder (
    .mode(rev_in),
    .din (bus_wdata),
    .dout(word_in)
  );

  assign byte_in = (rev_in == REV_NONE) ? byte_val : flip_lane(byte_val);

  crc_advance #(.CW(CRC_W), .IN_W(CRC_W)) u_adv_word (
    .crc_in (acc_q),
    .poly   (act_poly_q),
    .din    (word_in),
    .crc_out(nxt_word)
  );

  crc_advance #(.CW(CRC_W), .IN_W(LANE_W)) u_adv_byte (
    .crc_in (acc_q),
    .poly   (act_poly_q),
    .din    (byte_in),
    .crc_out(nxt_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q      <= RST_SEED;
      act_poly_q <= RST_POLY;
    end else if (load_p) begin
      acc_q      <= seed_val;
      act_poly_q <= poly_val;
    end else if (word_we) begin
      acc_q      <= nxt_word;
    end else if (byte_we) begin
      acc_q      <= nxt_byte;
    end
  end
endmodule

// File: rtl/crc_unit_checker.sv
module crc_unit_checker #(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_be,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic [31:0]       acc_q,
  input logic [31:0]       seed_q
);
  localparam logic [ADDR_W-1:0] C_DATA = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] C_CTRL = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] C_SEED = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] C_POLY = ADDR_W'('h14);

  a_r2_load_takes_seed: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_addr == C_CTRL && bus_be[0] && bus_wdata[0])
      |=> (acc_q == $past(seed_q)));

  a_r2_ctrl_bit0_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we && bus_addr == C_CTRL) |=> (bus_rdata[0] == 1'b0));

  a_r8_mode_write_keeps_acc: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_addr == C_CTRL && !(bus_be[0] && bus_wdata[0]))
      |=> $stable(acc_q));

  a_r9_cfg_write_keeps_acc: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && (bus_addr == C_SEED || bus_addr == C_POLY))
      |=> $stable(acc_q));

  a_r4_odd_be_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_addr == C_DATA && bus_be != 4'hF && !$onehot(bus_be))
      |=> $stable(acc_q));

  a_r11_read_strobe: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we) |=> bus_rvalid);

  a_r11_no_stray_strobe: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_we) |=> !bus_rvalid);

  a_r11_read_keeps_acc: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we) |=> $stable(acc_q));
endmodule

bind prog_crc_unit crc_unit_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_rvalid(bus_rvalid),
  .acc_q     (acc_q),
  .seed_q    (seed_val)
);

// File: tb/prog_crc_unit_bench.sv
`timescale 1ns/1ps
module prog_crc_unit_bench;
  localparam logic [4:0] A_DATA = 5'h00;
  localparam logic [4:0] A_CTRL = 5'h08;
  localparam logic [4:0] A_SEED = 5'h10;
  localparam logic [4:0] A_POLY = 5'h14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  int n_chk = 0;
  int n_fail = 0;

  // bench-side model state
  logic [31:0] m_acc = 32'hFFFF_FFFF;
  logic [31:0] m_apoly = 32'h04C1_1DB7;
  logic [31:0] m_seed = 32'hFFFF_FFFF;
  logic [31:0] m_poly = 32'h04C1_1DB7;
  logic [1:0]  m_mode = 2'b00;
  logic        m_rout = 1'b0;

  always #2 clk = ~clk;

  prog_crc_unit u_prog_crc_unit (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  function automatic logic [31:0] m_step(input logic [31:0] crc, input logic [31:0] p,
                                         input logic [31:0] d, input int nbits);
    logic [31:0] c = crc;
    for (int i = nbits - 1; i >= 0; i--) begin
      if (c[31] != d[i]) c = (c << 1) ^ p;
      else               c = c << 1;
    end
    return c;
  endfunction

  function automatic logic [31:0] m_grp_rev(input logic [31:0] x, input int g);
    logic [31:0] r;
    for (int k = 0; k < 32 / g; k++)
      for (int j = 0; j < g; j++) r[k*g + j] = x[k*g + g - 1 - j];
    return r;
  endfunction

  function automatic logic [31:0] m_word_in(input logic [31:0] d);
    case (m_mode)
      2'b00:   return d;
      2'b01:   return m_grp_rev(d, 8);
      2'b10:   return m_grp_rev(d, 16);
      default: return m_grp_rev(d, 32);
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic access(input logic we, input logic [4:0] a, input logic [31:0] d,
                        input logic [3:0] be);
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d, output logic v);
    access(1'b0, a, 32'h0, 4'h0);
    d = bus_rdata;
    v = bus_rvalid;
  endtask

  task automatic op_word(input logic [31:0] d);
    access(1'b1, A_DATA, d, 4'hF);
    m_acc = m_step(m_acc, m_apoly, m_word_in(d), 32);
  endtask

  task automatic op_byte(input int lane, input logic [7:0] b);
    logic [31:0] d = $urandom;
    logic [7:0]  bi;
    d[lane*8 +: 8] = b;
    access(1'b1, A_DATA, d, 4'(1 << lane));
    bi = b;
    if (m_mode != 2'b00)
      for (int i = 0; i < 8; i++) bi[i] = b[7-i];
    m_acc = m_step(m_acc, m_apoly, {24'h0, bi}, 8);
  endtask

  task automatic op_ctrl(input logic [7:0] v);
    access(1'b1, A_CTRL, {24'h5A5A5A, v}, 4'h1);
    m_mode = v[6:5];
    m_rout = v[7];
    if (v[0]) begin m_acc = m_seed; m_apoly = m_poly; end
  endtask

  task automatic op_seed(input logic [31:0] d);
    access(1'b1, A_SEED, d, 4'hF);
    m_seed = d;
  endtask

  task automatic op_poly(input logic [31:0] d);
    access(1'b1, A_POLY, d, 4'hF);
    m_poly = d;
  endtask

  task automatic chk_data(input string tag);
    logic [31:0] g;
    logic v;
    rd(A_DATA, g, v);
    chk(tag, g, m_rout ? m_grp_rev(m_acc, 32) : m_acc);
    chk({tag, " strobe"}, {31'h0, v}, 32'h1);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] g;
    logic v;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(A_DATA, g, v); chk("R1 data", g, 32'hFFFF_FFFF);
    rd(A_CTRL, g, v); chk("R1 ctrl", g, 32'h0);
    rd(A_SEED, g, v); chk("R1 seed", g, 32'hFFFF_FFFF);
    rd(A_POLY, g, v); chk("R1 poly", g, 32'h04C1_1DB7);

    // R4 byte stream, MSB-first check value
    op_ctrl(8'h01);
    for (int i = 0; i < 9; i++) op_byte(i % 4, 8'(8'h31 + i));
    rd(A_DATA, g, v); chk("R4 byte stream", g, 32'h0376_E6E7);

    // R3 word path gives the same value
    op_ctrl(8'h01);
    op_word(32'h3132_3334);
    op_word(32'h3536_3738);
    op_byte(3, 8'h39);
    rd(A_DATA, g, v); chk("R3 word stream", g, 32'h0376_E6E7);

    // R6 R7 reflected byte stream
    op_ctrl(8'hA1);
    for (int i = 0; i < 9; i++) op_byte(0, 8'(8'h31 + i));
    rd(A_DATA, g, v); chk("R6 R7 reflected bytes", g, 32'h340B_C6D9);

    // R5 whole-word reversal, R6 byte under code 11
    op_ctrl(8'hE1);
    op_word(32'h3433_3231);
    op_word(32'h3837_3635);
    op_byte(1, 8'h39);
    rd(A_DATA, g, v); chk("R5 reflected words", g, 32'h340B_C6D9);

    // R2 R7 control readback
    rd(A_CTRL, g, v); chk("R2 ctrl readback", g, 32'h0000_00E0);

    // R10 save and restore
    op_ctrl(8'h01);
    op_word(32'h3132_3334);
    rd(A_DATA, g, v);
    op_seed(g);
    op_ctrl(8'h01);
    op_word(32'h3536_3738);
    op_byte(2, 8'h39);
    rd(A_DATA, g, v); chk("R10 resumed", g, 32'h0376_E6E7);
    op_seed(32'hFFFF_FFFF);

    // R8 mode-only write keeps the checksum, then R5 half mode
    op_ctrl(8'h01);
    op_word(32'hDEAD_BEEF);
    rd(A_DATA, g, v);
    op_ctrl(8'h40);
    begin
      logic [31:0] g2;
      rd(A_DATA, g2, v); chk("R8 mode write", g2, g);
    end
    op_word(32'h1234_5678);
    chk_data("R5 half mode");

    // R9 seed and poly writes do not touch the checksum
    op_seed(32'h0BAD_F00D);
    op_poly(32'h1EDC_6F41);
    chk_data("R9 after cfg writes");
    op_word(32'hCAFE_0001);
    chk_data("R9 old poly still used");
    op_ctrl(8'h01);
    chk_data("R9 load takes new cfg");
    op_word(32'hCAFE_0002);
    chk_data("R9 new poly used");

    // R4 odd byte-enable patterns ignored
    access(1'b1, A_DATA, 32'hFFFF_FFFF, 4'b0011);
    access(1'b1, A_DATA, 32'hFFFF_FFFF, 4'b0000);
    access(1'b1, A_DATA, 32'hFFFF_FFFF, 4'b1110);
    chk_data("R4 odd enables");

    // R11 back-to-back write then read, strobe drops when idle
    op_word(32'h0F0F_F0F0);
    chk_data("R11 read after write");
    @(negedge clk);
    chk("R11 idle strobe", {31'h0, bus_rvalid}, 32'h0);

    // R12 load and mode change in one control write
    op_byte(1, 8'h77);
    op_ctrl(8'h21);
    chk_data("R12 loaded");
    op_byte(2, 8'h81);
    chk_data("R12 new mode applied");

    // random mix
    op_poly(32'h04C1_1DB7);
    op_seed(32'hFFFF_FFFF);
    op_ctrl(8'h01);
    for (int n = 0; n < 3000; n++) begin
      int sel = $urandom_range(0, 19);
      if (sel < 8)       op_word($urandom);
      else if (sel < 14) op_byte($urandom_range(0, 3), 8'($urandom));
      else if (sel < 16) op_ctrl({$urandom_range(0, 7) == 0 ? 1'b1 : 1'b0, 2'($urandom), 4'h0,
                                  1'($urandom)} | 8'h0);
      else if (sel == 16) op_seed($urandom);
      else if (sel == 17 && $urandom_range(0, 3) == 0) op_poly($urandom);
      else chk_data("R3 R5 R6 R7 random");
    end
    chk_data("R3 random final");

    finish_run();
  end
endmodule